// File: doc/BRIEF.md
# Inline Storage Cipher Security State Controller

This block decides when an inline storage-encryption engine may move data and under which security state. After every reset it drives an external AES datapath through two known-answer tests, first an AES-256 ECB encryption and then an AES-256 ECB decryption. It compares each 128-bit result with a stored constant. Until both tests pass, the data-in and data-out FIFO handshakes stay shut. If both pass, the engine becomes operational and is flagged approved. If either fails, the controller locks into a failure state. Only a reset can clear that state, and the reset reruns the tests.

Software or a host sequencer opens a service through a request port. Only one service can be open at a time. Data handshakes pass through only while a service is open. Selecting the legacy disk-encryption service drops the approved flag, and the flag stays low until the next reset. A status word reports the state of the block. An interrupt pulses once when the test sequence finishes, whether it passed or failed.

Top module: `crypt_state_ctrl`

## Requirements
- R1: After reset the block runs two tests in a fixed order: first encrypt, with kat_decrypt=0 and kat_block equal to the plaintext constant; then decrypt, with kat_decrypt=1 and kat_block equal to the ciphertext constant. Each test starts with a one-cycle kat_start and uses kat_key equal to the key constant. The second test starts only after cipher_done for the first. kat_active and status[1] (testing) are high from reset until the sequence ends.
- R2: The four gated handshakes are up_ready, eng_in_valid, eng_out_ready and dn_valid. Each is 0 unless the block is operational and a service is open. When both hold, up_ready=eng_in_ready, eng_in_valid=up_valid, eng_out_ready=dn_ready and dn_valid=eng_out_valid.
- R3: When both results match, the block becomes operational with status[0]=1 and status[3] (approved)=1. The approved flag is set only at this point.
- R4: Accepting a legacy request (svc_legacy=1) clears status[3]. Later approved requests do not set it again; only a reset followed by a passing sequence does.
- R5: A mismatch in any single bit of either 128-bit result enters the failure state. In that state status[2]=1, status[0]=0, all four handshakes are shut, every request is refused, and the datapath is not started again.
- R6: The failure state persists until reset. Reset reruns the tests: a repeated failure returns the block to the failure state, and a pass makes it operational.
- R7: A request is accepted only when the block is operational and no service is open. Acceptance gives a one-cycle svc_ack in the cycle after the request. Any other request gives a one-cycle svc_nak. svc_end closes an open service, and status[5] shows that a service is open.
- R8: status[4] (service indicator) is 0 while an approved (ECB/XTS) service is open, and 1 while a legacy service is open or no service is open.
- R9: irq_test_done is high for exactly one cycle, the first cycle in which the block has left testing for either the operational or the failure state.
- R10: The status bit layout is [0] operational, [1] testing, [2] self-test failure, [3] approved, [4] service indicator, [5] service open. While reset is held, status reads 6'b010010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the test sequence |
| kat_start | output | 1 | One-cycle start to the AES datapath for a test |
| kat_decrypt | output | 1 | Test direction: 0 encrypt, 1 decrypt |
| kat_active | output | 1 | Holds the datapath in test mode |
| kat_key | output | KEY_W | Test key, zero outside testing |
| kat_block | output | BLK_W | Test input block |
| cipher_done | input | 1 | Datapath result valid |
| cipher_result | input | BLK_W | Datapath result |
| up_valid | input | 1 | Data-in source valid |
| up_ready | output | 1 | Gated ready back to the data-in source |
| eng_in_valid | output | 1 | Gated valid into the engine |
| eng_in_ready | input | 1 | Engine ready for input |
| eng_out_valid | input | 1 | Engine output valid |
| eng_out_ready | output | 1 | Gated ready to the engine output |
| dn_valid | output | 1 | Gated valid toward the data-out sink |
| dn_ready | input | 1 | Data-out sink ready |
| svc_req | input | 1 | Service request |
| svc_legacy | input | 1 | Requested service is the legacy (non-approved) mode |
| svc_end | input | 1 | Close the open service |
| svc_ack | output | 1 | Request accepted, one cycle |
| svc_nak | output | 1 | Request refused, one cycle |
| status | output | 6 | Status word, layout in R10 |
| irq_test_done | output | 1 | Test sequence finished, one cycle |

## Verification
The test sequence is driven with randomly delayed datapath answers. Each answer is either correct or has one flipped bit, chosen at random or placed at bit 0 or bit 127. This separates a full-width compare from a partial one, and a failure in the first test from one in the second. Handshake inputs are randomised in three situations: while testing, while operational with no service open, and while a service is open. Only the last may pass traffic. Service requests are ordered approved, concurrent, legacy and then approved again, which shows that the approved flag drops once and does not return before a reset.

// File: rtl/crypt_state_ctrl.sv
module crypt_state_ctrl #(
  parameter int BLK_W = 128,
  parameter int KEY_W = 256,
  parameter logic [KEY_W-1:0] KAT_KEY =
    256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
  parameter logic [BLK_W-1:0] KAT_PLAIN  = 128'h00112233445566778899aabbccddeeff,
  parameter logic [BLK_W-1:0] KAT_CIPHER = 128'h8ea2b7ca516745bfeafc49904b496089
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             kat_start,
  output logic             kat_decrypt,
  output logic             kat_active,
  output logic [KEY_W-1:0] kat_key,
  output logic [BLK_W-1:0] kat_block,
  input  logic             cipher_done,
  input  logic [BLK_W-1:0] cipher_result,
  input  logic             up_valid,
  output logic             up_ready,
  output logic             eng_in_valid,
  input  logic             eng_in_ready,
  input  logic             eng_out_valid,
  output logic             eng_out_ready,
  output logic             dn_valid,
  input  logic             dn_ready,
  input  logic             svc_req,
  input  logic             svc_legacy,
  input  logic             svc_end,
  output logic             svc_ack,
  output logic             svc_nak,
  output logic [5:0]       status,
  output logic             irq_test_done
);

  typedef enum logic [2:0] {
    S_BOOT, S_ENC_GO, S_ENC_WAIT, S_DEC_GO, S_DEC_WAIT, S_OPER, S_FAIL
  } st_t;

  st_t  state;
  logic approved_q, busy_q, legacy_q, ack_q, nak_q, irq_q;

  logic testing, oper, in_wait, match, accept, gate;

  assign testing = (state != S_OPER) && (state != S_FAIL);
  assign oper    = (state == S_OPER);
  assign in_wait = (state == S_ENC_WAIT) || (state == S_DEC_WAIT);
  assign match   = cipher_result == ((state == S_DEC_WAIT) ? KAT_PLAIN : KAT_CIPHER);
  assign accept  = oper && svc_req && !busy_q;
  assign gate    = oper && busy_q;

  assign kat_start   = (state == S_ENC_GO) || (state == S_DEC_GO);
  assign kat_decrypt = (state == S_DEC_GO) || (state == S_DEC_WAIT);
  assign kat_active  = testing;
  assign kat_key     = testing ? KAT_KEY : '0;
  assign kat_block   = kat_decrypt ? KAT_CIPHER : KAT_PLAIN;

  assign up_ready      = gate & eng_in_ready;
  assign eng_in_valid  = gate & up_valid;
  assign eng_out_ready = gate & dn_ready;
  assign dn_valid      = gate & eng_out_valid;

  assign svc_ack       = ack_q;
  assign svc_nak       = nak_q;
  assign irq_test_done = irq_q;
  assign status = {busy_q, !(busy_q && !legacy_q), approved_q,
                   state == S_FAIL, testing, oper};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_BOOT;
    end else begin
      case (state)
        S_BOOT:     state <= S_ENC_GO;
        S_ENC_GO:   state <= S_ENC_WAIT;
        S_ENC_WAIT: if (cipher_done) state <= match ? S_DEC_GO : S_FAIL;
        S_DEC_GO:   state <= S_DEC_WAIT;
        S_DEC_WAIT: if (cipher_done) state <= match ? S_OPER : S_FAIL;
        S_OPER:     state <= S_OPER;
        default:    state <= S_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q      <= 1'b0;
      approved_q <= 1'b0;
      busy_q     <= 1'b0;
      legacy_q   <= 1'b0;
      ack_q      <= 1'b0;
      nak_q      <= 1'b0;
    end else begin
      irq_q <= in_wait && cipher_done && (!match || state == S_DEC_WAIT);
      ack_q <= accept;
      nak_q <= svc_req && !accept;
      if (state == S_DEC_WAIT && cipher_done && match)
        approved_q <= 1'b1;
      else if (accept && svc_legacy)
        approved_q <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        legacy_q <= svc_legacy;
      end else if (busy_q && svc_end) begin
        busy_q   <= 1'b0;
        legacy_q <= 1'b0;
      end
    end
  end

endmodule

module crypt_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       kat_start,
  input logic       irq_test_done,
  input logic [5:0] status,
  input logic       svc_req,
  input logic       svc_ack,
  input logic       svc_nak,
  input logic       up_ready,
  input logic       eng_in_valid,
  input logic       eng_out_ready,
  input logic       dn_valid
);

  p_start_testing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    kat_start |-> status[1]);
  p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    kat_start |=> !kat_start);
  p_gate_shut_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> !(up_ready || eng_in_valid || eng_out_ready || dn_valid));
  p_approved_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(status[1]));
  p_legacy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack && status[4]) |-> !status[3]);
  p_fail_shut_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> (!status[0] && !kat_start && !svc_ack));
  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |=> status[2]);
  p_busy_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && svc_req) |=> (svc_nak && !svc_ack));
  p_ack_nak_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(svc_ack && svc_nak));
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_test_done |=> !irq_test_done);
  p_fail_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> irq_test_done);

endmodule

bind crypt_state_ctrl crypt_state_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .kat_start(kat_start), .irq_test_done(irq_test_done),
  .status(status), .svc_req(svc_req), .svc_ack(svc_ack), .svc_nak(svc_nak),
  .up_ready(up_ready), .eng_in_valid(eng_in_valid), .eng_out_ready(eng_out_ready),
  .dn_valid(dn_valid)
);

// File: tb/crypt_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module crypt_state_ctrl_tb_top;

  localparam logic [255:0] T_KEY =
    256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
  localparam logic [127:0] T_PT = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] T_CT = 128'h8ea2b7ca516745bfeafc49904b496089;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kat_start, kat_decrypt, kat_active;
  logic [255:0] kat_key;
  logic [127:0] kat_block;
  logic cipher_done = 1'b0;
  logic [127:0] cipher_result = '0;
  logic up_valid = 0, eng_in_ready = 0, eng_out_valid = 0, dn_ready = 0;
  logic up_ready, eng_in_valid, eng_out_ready, dn_valid;
  logic svc_req = 0, svc_legacy = 0, svc_end = 0;
  logic svc_ack, svc_nak, irq_test_done;
  logic [5:0] status;

  int checks = 0;
  int fails = 0;
  bit m_oper, m_test, m_fail, m_appr, m_busy, m_leg;

  always #2.5 clk = ~clk;

  crypt_state_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .kat_start(kat_start), .kat_decrypt(kat_decrypt),
    .kat_active(kat_active), .kat_key(kat_key), .kat_block(kat_block),
    .cipher_done(cipher_done), .cipher_result(cipher_result),
    .up_valid(up_valid), .up_ready(up_ready), .eng_in_valid(eng_in_valid),
    .eng_in_ready(eng_in_ready), .eng_out_valid(eng_out_valid),
    .eng_out_ready(eng_out_ready), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .svc_req(svc_req), .svc_legacy(svc_legacy), .svc_end(svc_end),
    .svc_ack(svc_ack), .svc_nak(svc_nak), .status(status),
    .irq_test_done(irq_test_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_status();
    return {m_busy, !(m_busy && !m_leg), m_appr, m_fail, m_test, m_oper};
  endfunction

  function automatic logic [3:0] exp_gate(input logic [3:0] in);
    bit g = m_oper && m_busy;
    return {g & in[3], g & in[2], g & in[1], g & in[0]};
  endfunction

  task automatic chk_status(input string tag);
    chk(status === exp_status(), tag, status, exp_status());
  endtask

  task automatic chk_gate(input string tag);
    logic [3:0] in = 4'($urandom());
    {up_valid, eng_in_ready, eng_out_valid, dn_ready} = in;
    #1;
    chk({eng_in_valid, up_ready, dn_valid, eng_out_ready} === exp_gate(in), tag,
        {eng_in_valid, up_ready, dn_valid, eng_out_ready}, exp_gate(in));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    svc_req = 0; svc_end = 0; cipher_done = 0;
    m_oper = 0; m_test = 1; m_fail = 0; m_appr = 0; m_busy = 0; m_leg = 0;
    repeat (2) @(negedge clk);
    chk(status === 6'b010010, "R10 status under reset", status, 6'b010010);
    rst_n = 1'b1;
  endtask

  task automatic serve_kat(input bit dec, input int flip);
    int guard = 0;
    int lat;
    logic [127:0] good;
    while (kat_start !== 1'b1 && guard < 20) begin
      chk(kat_start === 1'b0 && kat_active === 1'b1, "R1 idle before start",
          {kat_start, kat_active}, 2'b01);
      @(negedge clk);
      guard++;
    end
    chk(kat_start === 1'b1, "R1 start seen", kat_start, 1);
    chk(kat_decrypt === dec, "R1 test order", kat_decrypt, dec);
    chk(kat_block === (dec ? T_CT : T_PT), "R1 test block", kat_block, dec ? T_CT : T_PT);
    chk(kat_key === T_KEY, "R1 test key", kat_key, T_KEY);
    chk_gate("R2 shut while testing");
    chk_status("R1 testing status");
    lat = $urandom_range(1, 6);
    repeat (lat) begin
      @(negedge clk);
      chk(kat_start === 1'b0, "R1 start single cycle", kat_start, 0);
    end
    good = dec ? T_PT : T_CT;
    cipher_result = (flip >= 0) ? (good ^ (128'd1 << flip)) : good;
    cipher_done = 1'b1;
    @(negedge clk);
    cipher_done = 1'b0;
    cipher_result = {4{$urandom()}};
  endtask

  task automatic selftest(input int enc_flip, input int dec_flip);
    serve_kat(1'b0, enc_flip);
    if (enc_flip < 0) serve_kat(1'b1, dec_flip);
    m_test = 0;
    if (enc_flip < 0 && dec_flip < 0) begin
      m_oper = 1; m_appr = 1;
      chk_status("R3 pass enters approved operation");
    end else begin
      m_fail = 1;
      chk_status("R5 mismatch enters failure");
    end
    chk(irq_test_done === 1'b1, "R9 irq at completion", irq_test_done, 1);
    @(negedge clk);
    chk(irq_test_done === 1'b0, "R9 irq one cycle", irq_test_done, 0);
  endtask

  task automatic service(input bit legacy, input string tag);
    bit acc;
    svc_req = 1; svc_legacy = legacy;
    @(negedge clk);
    svc_req = 0;
    acc = m_oper && !m_busy;
    chk(svc_ack === acc && svc_nak === !acc, {tag, " R7 ack/nak"},
        {svc_ack, svc_nak}, {acc, !acc});
    if (acc) begin
      m_busy = 1; m_leg = legacy;
      if (legacy) m_appr = 0;
    end
    chk_status({tag, " R8 status after request"});
    @(negedge clk);
    chk(svc_ack === 1'b0 && svc_nak === 1'b0, "R7 response one cycle",
        {svc_ack, svc_nak}, 2'b00);
  endtask

  task automatic end_service();
    svc_end = 1;
    @(negedge clk);
    svc_end = 0;
    m_busy = 0; m_leg = 0;
    chk_status("R7 service closed");
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired: actual running expected finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    selftest(-1, -1);

    for (int i = 0; i < 8; i++) begin
      chk_gate("R2 shut with no service");
      @(negedge clk);
    end

    service(1'b0, "approved");
    chk(status[4] === 1'b0, "R8 indicator approved", status[4], 0);
    for (int i = 0; i < 40; i++) begin
      chk_gate("R2 pass-through");
      @(negedge clk);
    end
    service(1'b0, "concurrent R7");
    service(1'b1, "concurrent legacy R7");
    chk(status[3] === 1'b1, "R4 refused legacy keeps approved", status[3], 1);
    end_service();

    service(1'b1, "legacy");
    chk(status[3] === 1'b0 && status[4] === 1'b1, "R4 legacy drops approved",
        status[4:3], 2'b10);
    for (int i = 0; i < 10; i++) begin
      chk_gate("R2 legacy pass-through");
      @(negedge clk);
    end
    end_service();
    service(1'b0, "approved after legacy");
    chk(status[3] === 1'b0 && status[4] === 1'b0, "R4 approved stays low",
        status[4:3], 2'b00);
    end_service();

    do_reset();
    selftest(-1, -1);
    chk(status[3] === 1'b1, "R6 reset restores approved", status[3], 1);

    do_reset();
    selftest($urandom_range(0, 127), -1);
    for (int i = 0; i < 12; i++) begin
      chk_gate("R5 shut in failure");
      if (i % 4 == 0) service(1'b0, "R5 refused in failure");
      chk(kat_start === 1'b0, "R5 no restart", kat_start, 0);
      chk(irq_test_done === 1'b0, "R9 no repeat irq", irq_test_done, 0);
      chk_status("R6 failure persists");
      @(negedge clk);
    end

    do_reset();
    selftest(-1, 127);
    do_reset();
    selftest(0, -1);
    chk_status("R6 repeated failure");
    do_reset();
    selftest(-1, -1);
    service(1'b0, "R6 recovered");

    for (int r = 0; r < 6; r++) begin
      int ef = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 127)) : -1;
      int df = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 127)) : -1;
      do_reset();
      selftest(ef, df);
      service($urandom_range(0, 1) == 1, "R7 random round");
      for (int i = 0; i < 6; i++) begin
        chk_gate("R2 random round");
        @(negedge clk);
      end
    end

    report();
    $finish;
  end

endmodule